// File: doc/BRIEF.md
# SPI Flash Passthrough Command Filter

This block sits on the wires between an SPI host and a downstream SPI flash. It samples the host pins with the system clock and collects the eight-bit opcode that opens each transaction. It then looks the opcode up in a table of command slots and decides whether the transaction may reach the flash. A transaction is blocked when its opcode has its bit set in a 256-entry block vector, or when no valid slot carries that opcode.

The downstream chip select stays high until that decision is made. A forwarded transaction opens with a fast replay of the opcode toward the flash. After that the host clock is mirrored, and each following host bit is forwarded through a bit-serial substitution unit. Per slot, this unit can overwrite masked address bits and, on commands that carry host data, masked bits among the first 32 payload bits. For the bits it changes, the output is `(in & ~mask) | (data & mask)`.

The address length is 24 or 32 bits. It follows a mode flag that two dedicated slots set and clear. On a blocked transaction the host data-return line is never driven.

Top module: `pf_passthru_filter`

## Requirements
- R1: During reset and after it, the downstream chip select is high, downstream SCK is low, the host data-return enable is low and the 4-byte address mode flag is 0.
- R2: The downstream chip select stays high while the opcode is being collected and decided. A forwarded transaction then shows the downstream device the opcode MSB first, followed by every later host bit in order.
- R3: When the block-vector bit indexed by the opcode value is 1, the downstream chip select stays high for the whole transaction and downstream SCK never toggles.
- R4: An opcode that matches no slot with its valid bit set is blocked in the same way as R3.
- R5: When several valid slots hold the same opcode, the slot with the lowest index supplies the configuration.
- R6: With address substitution enabled in the selected slot, each address bit whose mask bit (bit position = address bit position) is 1 is replaced by the data bit. Address bits arrive MSB first. With it disabled, the address passes unchanged.
- R7: The address phase is 24 bits when the mode flag is 0 and 32 bits when it is 1. A slot whose address flag is 0 has no address phase.
- R8: A forwarded transaction matched to slot 3 sets the mode flag, and one matched to slot 4 clears it. The change takes effect when the host chip select rises. A blocked transaction leaves the flag unchanged.
- R9: The payload begins after the address phase plus the slot's dummy count (0 to 15). Payload substitution is applied only in slots that have it enabled and whose direction is host-to-device. Payload bit j (j = 0 first on the wire) uses mask/data bit 31-j. Payload bits from j = 32 on, and dummy bits, pass unchanged.
- R10: On a forwarded transaction the host data-return line is driven, with the downstream data, once the opcode replay is over. On a blocked transaction its enable stays low throughout.
- R11: A transaction whose chip select rises before 8 opcode bits have been collected causes no downstream chip-select activity.
- R12: The opcode replay ends before the host SCK falls after its 8th rising edge, provided the host SCK half period is at least 20 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| op_block_i | input | 256 | Per-opcode block bits, indexed by opcode value |
| slot_valid_i | input | NSLOT | Slot valid bits |
| slot_opcode_i | input | NSLOT*8 | Slot opcodes, slot s at bits [8s+7:8s] |
| slot_has_addr_i | input | NSLOT | Slot has an address phase |
| slot_addr_xl_i | input | NSLOT | Slot enables address substitution |
| slot_pay_xl_i | input | NSLOT | Slot enables payload substitution |
| slot_rd_i | input | NSLOT | Slot payload flows device-to-host |
| slot_dummy_i | input | NSLOT*4 | Dummy bit count, slot s at bits [4s+3:4s] |
| addr_mask_i | input | 32 | Address substitution mask |
| addr_data_i | input | 32 | Address substitution data |
| pay_mask_i | input | 32 | Payload substitution mask |
| pay_data_i | input | 32 | Payload substitution data |
| host_csb_i | input | 1 | Host chip select, active low |
| host_sck_i | input | 1 | Host serial clock (mode 0) |
| host_mosi_i | input | 1 | Host data toward the block |
| host_miso_o | output | 1 | Data returned to the host |
| host_miso_oe_o | output | 1 | Drive enable for host_miso_o |
| dn_csb_o | output | 1 | Downstream chip select, active low |
| dn_sck_o | output | 1 | Downstream serial clock |
| dn_mosi_o | output | 1 | Data toward the downstream device |
| dn_miso_i | input | 1 | Data from the downstream device |
| addr4b_o | output | 1 | 4-byte address mode flag |

## Verification
Some properties are checked on every cycle. The downstream select stays high through opcode collection and through blocked transactions. A blocked transaction never enables the host return line. A missed lookup always leads to blocking. The address mode flag moves only at the close of a forwarded transaction. The host clock does not fall during the opcode replay. Other behaviour appears only through the bench's scenarios, which compare the captured downstream bit stream against a model. Those behaviours are the exact substituted bits, the 24/32-bit address boundary, the lowest-slot priority, the dummy offset and the 32-bit payload limit.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int ADDR_MAX = 32;
  localparam int DUMMY_W  = 4;
  localparam int OPC_W    = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_DECIDE, ST_REPLAY, ST_PASS, ST_BLOCK
  } pf_state_e;

  typedef struct packed {
    logic               has_addr;
    logic               addr_xl;
    logic               pay_xl;
    logic               rd;
    logic [DUMMY_W-1:0] dummy;
  } xlate_cfg_t;
endpackage

// File: rtl/pf_pin_sampler.sv
module pf_pin_sampler #(
  parameter int           W       = 1,
  parameter int           STAGES  = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pf_cmd_decoder.sv
module pf_cmd_decoder #(
  parameter int NSLOT = 24,
  parameter int IDX_W = 5
) (
  input  logic [NSLOT-1:0]       valid_i,
  input  logic [NSLOT*8-1:0]     opcodes_i,
  input  logic [7:0]             opcode_i,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [NSLOT-1:0] match;

  for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
    assign match[s] = valid_i[s] && (opcodes_i[s*8 +: 8] == opcode_i);
  end

  // lowest index wins: scan from the top so the last write is the lowest hit
  always_comb begin
    hit_o = |match;
    idx_o = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (match[s]) idx_o = IDX_W'(s);
    end
  end
endmodule

// File: rtl/pf_stream_xlate.sv
module pf_stream_xlate
  import pf_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PAY_XW = 32
) (
  input  logic                bit_i,
  input  logic [CNT_W-1:0]    idx_i,
  input  xlate_cfg_t          cfg_i,
  input  logic                addr4b_i,
  input  logic [ADDR_MAX-1:0] addr_mask_i,
  input  logic [ADDR_MAX-1:0] addr_data_i,
  input  logic [PAY_XW-1:0]   pay_mask_i,
  input  logic [PAY_XW-1:0]   pay_data_i,
  output logic                bit_o
);
  localparam int AP_W = $clog2(ADDR_MAX);
  localparam int PP_W = $clog2(PAY_XW);

  int              idx;
  int              alen;
  int              pstart;
  logic [AP_W-1:0] apos;
  logic [PP_W-1:0] ppos;

  always_comb begin
    idx    = int'(idx_i);
    alen   = cfg_i.has_addr ? (addr4b_i ? ADDR_MAX : ADDR_MAX - 8) : 0;
    pstart = alen + int'(cfg_i.dummy);
    apos   = AP_W'(alen - 1 - idx);
    ppos   = PP_W'(PAY_XW - 1 - (idx - pstart));
    bit_o  = bit_i;
    if (idx < alen) begin
      if (cfg_i.addr_xl && addr_mask_i[apos]) bit_o = addr_data_i[apos];
    end else if (idx >= pstart && idx < pstart + PAY_XW) begin
      if (cfg_i.pay_xl && !cfg_i.rd && pay_mask_i[ppos]) bit_o = pay_data_i[ppos];
    end
  end
endmodule

// File: rtl/pf_passthru_filter.sv
module pf_passthru_filter
  import pf_pkg::*;
#(
  parameter int NSLOT        = 24,
  parameter int ENTER4B_SLOT = 3,
  parameter int EXIT4B_SLOT  = 4,
  parameter int SYNC_STAGES  = 1,
  parameter bit ADDR4B_RST   = 1'b0,
  parameter int CNT_W        = 8,
  parameter int PAY_XW       = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [255:0]               op_block_i,
  input  logic [NSLOT-1:0]           slot_valid_i,
  input  logic [NSLOT*8-1:0]         slot_opcode_i,
  input  logic [NSLOT-1:0]           slot_has_addr_i,
  input  logic [NSLOT-1:0]           slot_addr_xl_i,
  input  logic [NSLOT-1:0]           slot_pay_xl_i,
  input  logic [NSLOT-1:0]           slot_rd_i,
  input  logic [NSLOT*DUMMY_W-1:0]   slot_dummy_i,
  input  logic [ADDR_MAX-1:0]        addr_mask_i,
  input  logic [ADDR_MAX-1:0]        addr_data_i,
  input  logic [PAY_XW-1:0]          pay_mask_i,
  input  logic [PAY_XW-1:0]          pay_data_i,
  input  logic                       host_csb_i,
  input  logic                       host_sck_i,
  input  logic                       host_mosi_i,
  output logic                       host_miso_o,
  output logic                       host_miso_oe_o,
  output logic                       dn_csb_o,
  output logic                       dn_sck_o,
  output logic                       dn_mosi_o,
  input  logic                       dn_miso_i,
  output logic                       addr4b_o
);
  localparam int IDX_W   = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int REPLAY_N = 2 * OPC_W;
  localparam int RC_W    = $clog2(REPLAY_N);

  // per-slot configuration gathered into structs
  xlate_cfg_t cfg [NSLOT];
  for (genvar s = 0; s < NSLOT; s++) begin : g_cfg
    assign cfg[s].has_addr = slot_has_addr_i[s];
    assign cfg[s].addr_xl  = slot_addr_xl_i[s];
    assign cfg[s].pay_xl   = slot_pay_xl_i[s];
    assign cfg[s].rd       = slot_rd_i[s];
    assign cfg[s].dummy    = slot_dummy_i[s*DUMMY_W +: DUMMY_W];
  end

  // pin sampling
  logic [2:0] hp;
  logic       dn_miso_s;
  pf_pin_sampler #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_host_smp (
    .clk(clk), .rst(rst), .d_i({host_csb_i, host_sck_i, host_mosi_i}), .q_o(hp)
  );
  pf_pin_sampler #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dn_smp (
    .clk(clk), .rst(rst), .d_i(dn_miso_i), .q_o(dn_miso_s)
  );

  logic csb_s, sck_s, mosi_s, sck_q, rise;
  assign csb_s  = hp[2];
  assign sck_s  = hp[1];
  assign mosi_s = hp[0];
  assign rise   = sck_s & ~sck_q;

  // state
  pf_state_e        state_q;
  logic [OPC_W-1:0] opc_q;
  logic [3:0]       bcnt_q;
  logic [RC_W-1:0]  rcnt_q;
  logic [CNT_W-1:0] pcnt_q;
  logic [IDX_W-1:0] sel_idx_q;
  xlate_cfg_t       sel_q;
  logic             addr4b_q;

  // lookup
  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  logic             allow;
  pf_cmd_decoder #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_dec (
    .valid_i(slot_valid_i), .opcodes_i(slot_opcode_i), .opcode_i(opc_q),
    .hit_o(dec_hit), .idx_o(dec_idx)
  );
  assign allow = dec_hit & ~op_block_i[opc_q];

  // bit-serial substitution
  logic xl_bit;
  pf_stream_xlate #(.CNT_W(CNT_W), .PAY_XW(PAY_XW)) u_xl (
    .bit_i(mosi_s), .idx_i(pcnt_q), .cfg_i(sel_q), .addr4b_i(addr4b_q),
    .addr_mask_i(addr_mask_i), .addr_data_i(addr_data_i),
    .pay_mask_i(pay_mask_i), .pay_data_i(pay_data_i), .bit_o(xl_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      opc_q          <= '0;
      bcnt_q         <= '0;
      rcnt_q         <= '0;
      pcnt_q         <= '0;
      sel_idx_q      <= '0;
      sel_q          <= '0;
      addr4b_q       <= ADDR4B_RST;
      dn_csb_o       <= 1'b1;
      dn_sck_o       <= 1'b0;
      dn_mosi_o      <= 1'b0;
      host_miso_o    <= 1'b0;
      host_miso_oe_o <= 1'b0;
    end else begin
      host_miso_o <= dn_miso_s;
      if (csb_s) begin
        if (state_q == ST_PASS) begin
          if (sel_idx_q == IDX_W'(ENTER4B_SLOT))     addr4b_q <= 1'b1;
          else if (sel_idx_q == IDX_W'(EXIT4B_SLOT)) addr4b_q <= 1'b0;
        end
        state_q        <= ST_IDLE;
        dn_csb_o       <= 1'b1;
        dn_sck_o       <= 1'b0;
        host_miso_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            bcnt_q  <= '0;
            state_q <= ST_OPC;
          end
          ST_OPC: begin
            if (rise) begin
              opc_q  <= {opc_q[OPC_W-2:0], mosi_s};
              bcnt_q <= bcnt_q + 4'd1;
              if (bcnt_q == 4'(OPC_W - 1)) state_q <= ST_DECIDE;
            end
          end
          ST_DECIDE: begin
            sel_q     <= cfg[dec_idx];
            sel_idx_q <= dec_idx;
            rcnt_q    <= '0;
            pcnt_q    <= '0;
            state_q   <= allow ? ST_REPLAY : ST_BLOCK;
          end
          ST_REPLAY: begin
            dn_csb_o  <= 1'b0;
            dn_sck_o  <= rcnt_q[0];
            dn_mosi_o <= opc_q[3'(OPC_W - 1) - rcnt_q[RC_W-1:1]];
            rcnt_q    <= rcnt_q + 1'b1;
            if (rcnt_q == RC_W'(REPLAY_N - 1)) state_q <= ST_PASS;
          end
          ST_PASS: begin
            dn_csb_o       <= 1'b0;
            host_miso_oe_o <= 1'b1;
            dn_sck_o       <= sck_s;
            if (!sck_s) dn_mosi_o <= xl_bit;
            if (rise && pcnt_q != '1) pcnt_q <= pcnt_q + 1'b1;
          end
          ST_BLOCK: begin
            dn_csb_o       <= 1'b1;
            host_miso_oe_o <= 1'b0;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign addr4b_o = addr4b_q;

  // downstream select held off until the opcode is decided
  p_hold_until_decided_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPC || state_q == ST_DECIDE) |-> dn_csb_o);

  // blocked transaction keeps the downstream side silent
  p_blocked_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BLOCK) |-> (dn_csb_o && !dn_sck_o));

  // a lookup miss leads to blocking
  p_miss_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DECIDE && !dec_hit && !csb_s) |=> (state_q == ST_BLOCK));

  // mode flag moves only when a forwarded transaction closes
  p_mode_at_close_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(addr4b_q) |-> ($past(state_q) == ST_PASS && $past(csb_s)));

  // host return line never driven on a blocked transaction
  p_no_drive_blocked_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BLOCK) |-> !host_miso_oe_o);

  // replay must not be overtaken by the host clock falling
  p_replay_fits_r12: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REPLAY) |-> !(sck_q && !sck_s));
endmodule

// File: tb/tb_pf_passthru_filter.sv
module tb_pf_passthru_filter;
  localparam int NSLOT = 24;
  localparam int H     = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst;
  logic [255:0]         op_block;
  logic [NSLOT-1:0]     slot_valid, slot_has_addr, slot_addr_xl, slot_pay_xl, slot_rd;
  logic [NSLOT*8-1:0]   slot_opcode;
  logic [NSLOT*4-1:0]   slot_dummy;
  logic [31:0]          addr_mask, addr_data, pay_mask, pay_data;
  logic                 h_csb, h_sck, h_mosi, dn_miso;
  logic                 host_miso, host_miso_oe, dn_csb, dn_sck, dn_mosi, addr4b;

  pf_passthru_filter #(.NSLOT(NSLOT)) dut (
    .clk(clk), .rst(rst), .op_block_i(op_block),
    .slot_valid_i(slot_valid), .slot_opcode_i(slot_opcode),
    .slot_has_addr_i(slot_has_addr), .slot_addr_xl_i(slot_addr_xl),
    .slot_pay_xl_i(slot_pay_xl), .slot_rd_i(slot_rd), .slot_dummy_i(slot_dummy),
    .addr_mask_i(addr_mask), .addr_data_i(addr_data),
    .pay_mask_i(pay_mask), .pay_data_i(pay_data),
    .host_csb_i(h_csb), .host_sck_i(h_sck), .host_mosi_i(h_mosi),
    .host_miso_o(host_miso), .host_miso_oe_o(host_miso_oe),
    .dn_csb_o(dn_csb), .dn_sck_o(dn_sck), .dn_mosi_o(dn_mosi),
    .dn_miso_i(dn_miso), .addr4b_o(addr4b)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  bit cap[$];
  bit expq[$];
  bit dn_act, saw_oe, miso_bad, prev_sck;
  bit m_addr4b;

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg_slot(int s, logic [7:0] op, bit v, bit ha, bit axl, bit pxl, bit rd, logic [3:0] dm);
    slot_valid[s]        = v;
    slot_opcode[s*8 +: 8] = op;
    slot_has_addr[s]     = ha;
    slot_addr_xl[s]      = axl;
    slot_pay_xl[s]       = pxl;
    slot_rd[s]           = rd;
    slot_dummy[s*4 +: 4] = dm;
  endtask

  // mode-0 host: data set while SCK low, sampled on rising edge
  task automatic send(logic [7:0] op, int nb, logic [127:0] body, int opbits);
    h_csb = 1'b0;
    tick(H);
    for (int i = 7; i >= 8 - opbits; i--) begin
      h_mosi = op[i]; tick(H); h_sck = 1'b1; tick(H); h_sck = 1'b0;
    end
    for (int i = nb - 1; i >= 0; i--) begin
      h_mosi = body[i]; tick(H); h_sck = 1'b1; tick(H); h_sck = 1'b0;
    end
    tick(H);
    h_csb = 1'b1;
    tick(4 * H);
  endtask

  task automatic clear_mon();
    cap.delete(); expq.delete();
    dn_act = 0; saw_oe = 0; miso_bad = 0;
  endtask

  // reference model: lookup, substitution, mode flag
  task automatic txn(logic [7:0] op, int nb, logic [127:0] body, string req);
    bit hit = 0;
    int si = 0;
    bit fwd;
    int alen, pst;
    logic [127:0] av, ev;
    clear_mon();
    for (int s = 0; s < NSLOT; s++)
      if (!hit && slot_valid[s] && slot_opcode[s*8 +: 8] == op) begin hit = 1; si = s; end
    fwd = hit && !op_block[op];
    if (fwd) begin
      for (int i = 7; i >= 0; i--) expq.push_back(op[i]);
      alen = slot_has_addr[si] ? (m_addr4b ? 32 : 24) : 0;
      pst  = alen + int'(slot_dummy[si*4 +: 4]);
      for (int k = 0; k < nb; k++) begin
        bit b;
        b = body[nb-1-k];
        if (k < alen) begin
          if (slot_addr_xl[si] && addr_mask[alen-1-k]) b = addr_data[alen-1-k];
        end else if (k >= pst && k < pst + 32) begin
          if (slot_pay_xl[si] && !slot_rd[si] && pay_mask[31-(k-pst)]) b = pay_data[31-(k-pst)];
        end
        expq.push_back(b);
      end
    end
    send(op, nb, body, 8);
    if (fwd && si == 3) m_addr4b = 1;
    else if (fwd && si == 4) m_addr4b = 0;
    av = '0; ev = '0;
    foreach (cap[i])  av = {av[126:0], cap[i]};
    foreach (expq[i]) ev = {ev[126:0], expq[i]};
    chk(cap.size() == expq.size() && av == ev, req, "downstream bit stream", av, ev);
    chk(dn_act == fwd, req, "downstream select activity", 128'(dn_act), 128'(fwd));
    chk(saw_oe == fwd && !miso_bad, req, "host return drive", {saw_oe, miso_bad}, {fwd, 1'b0});
    chk(addr4b == m_addr4b, req, "address mode flag", 128'(addr4b), 128'(m_addr4b));
  endtask

  // per-clock monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (!dn_csb) dn_act = 1;
      if (!dn_csb && dn_sck && !prev_sck) cap.push_back(dn_mosi);
      if (host_miso_oe) begin
        saw_oe = 1;
        if (host_miso !== 1'b1) miso_bad = 1;
      end
      prev_sck = dn_sck;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_block = '0;
    slot_valid = '0; slot_opcode = '0; slot_has_addr = '0; slot_addr_xl = '0;
    slot_pay_xl = '0; slot_rd = '0; slot_dummy = '0;
    addr_mask = 32'hFF00_F00F; addr_data = 32'h12A0_B00C;
    pay_mask  = 32'hF0F0_0FF0; pay_data  = 32'h5A5A_A5A5;
    h_csb = 1'b1; h_sck = 1'b0; h_mosi = 1'b0; dn_miso = 1'b1;
    m_addr4b = 0; prev_sck = 0;

    cfg_slot(0,  8'h05, 1, 0, 0, 0, 1, 4'd0);
    cfg_slot(3,  8'hB7, 1, 0, 0, 0, 0, 4'd0);
    cfg_slot(4,  8'hE9, 1, 0, 0, 0, 0, 4'd0);
    cfg_slot(5,  8'h03, 1, 1, 0, 0, 1, 4'd0);
    cfg_slot(6,  8'h0B, 1, 1, 1, 0, 1, 4'd8);
    cfg_slot(11, 8'h02, 1, 1, 0, 1, 0, 4'd0);
    cfg_slot(12, 8'h3B, 1, 1, 1, 0, 1, 4'd0);
    cfg_slot(13, 8'h3B, 1, 1, 0, 0, 1, 4'd0);
    cfg_slot(14, 8'h42, 0, 1, 0, 0, 1, 4'd0);
    cfg_slot(15, 8'h32, 1, 0, 0, 1, 0, 4'd4);

    tick(3);
    // R1: state held in reset
    chk(dn_csb == 1 && dn_sck == 0 && host_miso_oe == 0 && addr4b == 0, "R1",
        "state during reset", {dn_csb, dn_sck, host_miso_oe, addr4b}, 4'b1000);
    rst = 1'b0;
    tick(4);
    chk(dn_csb == 1 && dn_sck == 0 && host_miso_oe == 0 && addr4b == 0, "R1",
        "state after reset", {dn_csb, dn_sck, host_miso_oe, addr4b}, 4'b1000);

    txn(8'h03, 40, 128'h01_2345_6789, "R2 R10 R12");        // plain read, 3-byte address
    txn(8'h0B, 48, 128'hAB_CDEF_C3_1234, "R6");             // address substitution + dummy
    txn(8'h02, 64, 128'h00FF00_3C_12_34_56_78_9A, "R9");     // payload past 32 bits
    op_block[8'h02] = 1'b1;
    txn(8'h02, 32, 128'h112233_44, "R3");                  // blocked by vector
    op_block[8'h02] = 1'b0;
    txn(8'h77, 24, 128'hFFFFFF, "R4");                      // no slot
    txn(8'h42, 24, 128'h123456, "R4");                      // slot not valid
    txn(8'h3B, 32, 128'h0F0F0F_AA, "R5");                   // duplicate opcode, lowest slot
    txn(8'hB7, 0, 128'h0, "R8");                            // enter 4-byte mode
    txn(8'h0B, 56, 128'h8765_4321_00_BEEF, "R7 R6");        // 32-bit address
    txn(8'hE9, 0, 128'h0, "R8");                            // exit 4-byte mode
    op_block[8'hB7] = 1'b1;
    txn(8'hB7, 0, 128'h0, "R8");                            // blocked enter: no change
    op_block[8'hB7] = 1'b0;
    txn(8'h32, 44, 128'h9_FEDC_BA98_76, "R9");              // no address, 4 dummy bits
    txn(8'h05, 16, 128'h0000, "R10");                       // read, no address

    // R11: chip select rises after 5 opcode bits
    clear_mon();
    send(8'h03, 0, 128'h0, 5);
    chk(!dn_act && cap.size() == 0, "R11", "partial opcode forwarded",
        128'(cap.size()), 128'(0));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule